// File: doc/BRIEF.md
# Compare/Capture Timer Channel

This block is a single 16-bit timer channel for a larger chip. An up-counter advances on a count-enable pulse. Software picks the source of that pulse: either a tick from an internal clock divider that sits outside this block, or rising edges on an external event pin, which lets the channel count events. The counter has two 16-bit registers, A and B. In compare mode they act as match values. B sets the period, because a B match sends the counter back to zero. A sets the point in the period where the PWM output goes high. Software writes A and B into shadow buffers. The buffered values reach the active registers only when the counter restarts, so a period that is already under way is never disturbed.

In capture mode the same two registers latch the counter value. Each of two independent trigger pins latches into its own register. The event pin and both trigger pins pass through a two-flop synchronizer and a rising-edge detector. Four event flags (compare A, compare B, capture A, capture B) each have an enable, and the enabled flags are ORed into one level interrupt. Two overrun flags record a capture that arrives while the earlier capture flag is still set.

A three-state controller sequences the channel. Its states are STOP, RUN_CMP and RUN_CAP. A control write with the run bit set causes START_CMP (STOP to RUN_CMP) or START_CAP (STOP to RUN_CAP), depending on the mode bit. A control write with run clear causes HALT, from either run state back to STOP. A control write that keeps run set but changes the mode bit causes TO_CAP (RUN_CMP to RUN_CAP) or TO_CMP (RUN_CAP to RUN_CMP). Every other cycle holds the current state.

Top module: `cct_channel`

## Requirements
- R1: While a run state is active, the counter adds one for each selected count pulse and wraps from 0xFFFF to 0. In STOP the counter holds its value and count pulses are ignored.
- R2: A `cnt_clr_i` pulse sets the counter to 0 on the next clock. This takes priority over counting, works in every state, and copies both shadow buffers into the active A and B registers.
- R3: Control bit 1 selects the count source. With 0 the source is `tick_i`. With 1 it is one pulse per rising edge of `ext_evt_i`, taken after a two-flop synchronizer. The source that is not selected has no effect on the counter.
- R4: In RUN_CMP, a count pulse that arrives while the counter equals active B returns the counter to 0 instead of incrementing it, giving a period of B+1 pulses. It also sets flag bit 1 (compare B).
- R5: In RUN_CMP, a count pulse that arrives while the counter equals active A, with A less than B, sets the PWM output high and sets flag bit 0 (compare A). When A is greater than or equal to B, no A match occurs and the PWM output stays low.
- R6: The PWM output goes low on a B match and on a software clear, and it is forced low whenever the state is STOP.
- R7: Writes to `buf_a_we_i` and `buf_b_we_i` update only the shadow buffers. The readback of active A and B stays unchanged until a B match or a software clear.
- R8: In RUN_CAP, a synchronized rising edge on `cap_a_i` copies the counter into active A and sets flag bit 2. A rising edge on `cap_b_i` copies it into active B and sets flag bit 3. No B-match restart occurs in RUN_CAP.
- R9: A capture on A while flag bit 2 is already set sets flag bit 4 (overrun A). A capture on B while flag bit 3 is set sets flag bit 5 (overrun B).
- R10: `irq_o` is the OR of flag bits 3:0, each masked by the matching enable bit. Enables are written from `wdata_i[3:0]` with `ien_we_i`. Writing a 1 to a bit of `wdata_i[5:0]` with `flag_clr_we_i` clears that flag, and a set in the same cycle wins.
- R11: After reset, the state is STOP, and the counter, active registers, buffers, flags, enables, control bits, PWM output and interrupt are all 0.
- R12: A control write loads `wdata_i[2:0]`, with bit 0 = run, bit 1 = external source and bit 2 = capture mode. It moves the controller along the transitions named above. `ctl_o` reads back the three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal divided-clock count pulse |
| ext_evt_i | input | 1 | Asynchronous external event input |
| cap_a_i | input | 1 | Asynchronous capture trigger for register A |
| cap_b_i | input | 1 | Asynchronous capture trigger for register B |
| ctl_we_i | input | 1 | Control write strobe (run, source, mode) |
| cnt_clr_i | input | 1 | Software counter clear and buffer reload |
| buf_a_we_i | input | 1 | Write strobe for shadow buffer A |
| buf_b_we_i | input | 1 | Write strobe for shadow buffer B |
| ien_we_i | input | 1 | Interrupt enable write strobe |
| flag_clr_we_i | input | 1 | Write-one-to-clear strobe for the flags |
| wdata_i | input | 16 | Write data shared by all strobes |
| ctl_o | output | 3 | Control readback |
| cnt_o | output | 16 | Counter value |
| reg_a_o | output | 16 | Active register A |
| reg_b_o | output | 16 | Active register B |
| flags_o | output | 6 | Event and overrun flags |
| ien_o | output | 4 | Interrupt enables |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the counter only ever steps by one or returns to zero;
- the counter holds in STOP;
- a clear yields zero;
- the PWM output is low in STOP;
- active A changes in RUN_CMP only at a period restart;
- a capture flag rises together with the captured counter value;
- an A flag never rises while A is not below B.

Only the bench's scenarios show whole waveforms over several periods for different A/B pairs (including A equal to B, A above B and zero values), counting of external events while the internal tick is held active, overrun on a repeated capture, and interrupt masking with write-one-to-clear.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RUN_CMP = 2'd1,
        ST_RUN_CAP = 2'd2
    } cct_state_e;

    localparam int CTL_BITS = 3;
    localparam int CTL_RUN  = 0;
    localparam int CTL_EXT  = 1;
    localparam int CTL_CAP  = 2;

    localparam int NFLAGS   = 6;
    localparam int NIRQ     = 4;
    localparam int FLG_CMPA = 0;
    localparam int FLG_CMPB = 1;
    localparam int FLG_CAPA = 2;
    localparam int FLG_CAPB = 3;
    localparam int FLG_OVRA = 4;
    localparam int FLG_OVRB = 5;

    localparam int NSYNC    = 3;
    localparam int SY_EVT   = 0;
    localparam int SY_CAPA  = 1;
    localparam int SY_CAPB  = 2;

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cct_fsm.sv
module cct_fsm
    import cct_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_we_i,
    input  logic       run_i,
    input  logic       cap_i,
    output cct_state_e state_o,
    output logic       running_o,
    output logic       cmp_mode_o,
    output logic       cap_mode_o
);
    cct_state_e state_q, state_d;
    cct_state_e run_target;

    assign run_target = cap_i ? ST_RUN_CAP : ST_RUN_CMP;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                // START_CMP / START_CAP
                if (ctl_we_i && run_i) state_d = run_target;
            end
            ST_RUN_CMP, ST_RUN_CAP: begin
                // HALT, TO_CAP, TO_CMP
                if (ctl_we_i) state_d = run_i ? run_target : ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_STOP;
        else         state_q <= state_d;
    end

    always_comb begin
        running_o  = 1'b0;
        cmp_mode_o = 1'b0;
        cap_mode_o = 1'b0;
        unique case (state_q)
            ST_STOP:    ;
            ST_RUN_CMP: begin running_o = 1'b1; cmp_mode_o = 1'b1; end
            ST_RUN_CAP: begin running_o = 1'b1; cap_mode_o = 1'b1; end
            default:    ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/cct_core.sv
module cct_core #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         running_i,
    input  logic         cmp_mode_i,
    input  logic         cap_mode_i,
    input  logic         pulse_i,
    input  logic         clr_i,
    input  logic         buf_a_we_i,
    input  logic         buf_b_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         cap_a_rise_i,
    input  logic         cap_b_rise_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] act_a_o,
    output logic [W-1:0] act_b_o,
    output logic         pwm_o,
    output logic         hit_a_o,
    output logic         hit_b_o,
    output logic         grab_a_o,
    output logic         grab_b_o
);
    logic [W-1:0] cnt_q, buf_a_q, buf_b_q, act_a_q, act_b_q;
    logic         pwm_q;
    logic         step, reload;

    assign step     = running_i & pulse_i;
    assign hit_b_o  = cmp_mode_i & step & (cnt_q == act_b_q);
    assign hit_a_o  = cmp_mode_i & step & (cnt_q == act_a_q) & (act_a_q < act_b_q);
    assign grab_a_o = cap_mode_i & cap_a_rise_i;
    assign grab_b_o = cap_mode_i & cap_b_rise_i;
    assign reload   = clr_i | hit_b_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i || hit_b_o) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else begin
            if (buf_a_we_i) buf_a_q <= wdata_i;
            if (buf_b_we_i) buf_b_q <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_a_q <= '0;
            act_b_q <= '0;
        end else begin
            if (reload)        act_a_q <= buf_a_q;
            else if (grab_a_o) act_a_q <= cnt_q;
            if (reload)        act_b_q <= buf_b_q;
            else if (grab_b_o) act_b_q <= cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pwm_q <= 1'b0;
        end else if (reload || !running_i) begin
            pwm_q <= 1'b0;
        end else if (hit_a_o) begin
            pwm_q <= 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign act_a_o = act_a_q;
    assign act_b_o = act_b_q;
    assign pwm_o   = pwm_q & running_i;
endmodule

// File: rtl/cct_flags.sv
module cct_flags
    import cct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NFLAGS-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NFLAGS-1:0] clr_mask_i,
    input  logic              ien_we_i,
    input  logic [NIRQ-1:0]   ien_wdata_i,
    output logic [NFLAGS-1:0] flags_o,
    output logic [NIRQ-1:0]   ien_o,
    output logic              irq_o
);
    logic [NFLAGS-1:0] flags_q, wipe;
    logic [NIRQ-1:0]   ien_q;

    assign wipe = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
            ien_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~wipe) | set_i;
            if (ien_we_i) ien_q <= ien_wdata_i;
        end
    end

    assign flags_o = flags_q;
    assign ien_o   = ien_q;
    assign irq_o   = |(flags_q[NIRQ-1:0] & ien_q);
endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                ext_evt_i,
    input  logic                cap_a_i,
    input  logic                cap_b_i,
    input  logic                ctl_we_i,
    input  logic                cnt_clr_i,
    input  logic                buf_a_we_i,
    input  logic                buf_b_we_i,
    input  logic                ien_we_i,
    input  logic                flag_clr_we_i,
    input  logic [W-1:0]        wdata_i,
    output logic [CTL_BITS-1:0] ctl_o,
    output logic [W-1:0]        cnt_o,
    output logic [W-1:0]        reg_a_o,
    output logic [W-1:0]        reg_b_o,
    output logic [NFLAGS-1:0]   flags_o,
    output logic [NIRQ-1:0]     ien_o,
    output logic                pwm_o,
    output logic                irq_o
);
    logic [CTL_BITS-1:0] cfg_q;
    logic [NSYNC-1:0]    async_in, rise;
    cct_state_e          state;
    logic                running, cmp_mode, cap_mode, pulse;
    logic                hit_a, hit_b, grab_a, grab_b;
    logic [NFLAGS-1:0]   set_vec;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cfg_q <= '0;
        else if (ctl_we_i) cfg_q <= wdata_i[CTL_BITS-1:0];
    end

    assign async_in[SY_EVT]  = ext_evt_i;
    assign async_in[SY_CAPA] = cap_a_i;
    assign async_in[SY_CAPB] = cap_b_i;

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(async_in[g]),
            .rise_o (rise[g])
        );
    end

    cct_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctl_we_i  (ctl_we_i),
        .run_i     (wdata_i[CTL_RUN]),
        .cap_i     (wdata_i[CTL_CAP]),
        .state_o   (state),
        .running_o (running),
        .cmp_mode_o(cmp_mode),
        .cap_mode_o(cap_mode)
    );

    assign pulse = cfg_q[CTL_EXT] ? rise[SY_EVT] : tick_i;

    cct_core #(.W(W)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .running_i   (running),
        .cmp_mode_i  (cmp_mode),
        .cap_mode_i  (cap_mode),
        .pulse_i     (pulse),
        .clr_i       (cnt_clr_i),
        .buf_a_we_i  (buf_a_we_i),
        .buf_b_we_i  (buf_b_we_i),
        .wdata_i     (wdata_i),
        .cap_a_rise_i(rise[SY_CAPA]),
        .cap_b_rise_i(rise[SY_CAPB]),
        .cnt_o       (cnt_o),
        .act_a_o     (reg_a_o),
        .act_b_o     (reg_b_o),
        .pwm_o       (pwm_o),
        .hit_a_o     (hit_a),
        .hit_b_o     (hit_b),
        .grab_a_o    (grab_a),
        .grab_b_o    (grab_b)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_CMPA] = hit_a;
        set_vec[FLG_CMPB] = hit_b;
        set_vec[FLG_CAPA] = grab_a;
        set_vec[FLG_CAPB] = grab_b;
        set_vec[FLG_OVRA] = grab_a & flags_o[FLG_CAPA];
        set_vec[FLG_OVRB] = grab_b & flags_o[FLG_CAPB];
    end

    cct_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (set_vec),
        .clr_we_i   (flag_clr_we_i),
        .clr_mask_i (wdata_i[NFLAGS-1:0]),
        .ien_we_i   (ien_we_i),
        .ien_wdata_i(wdata_i[NIRQ-1:0]),
        .flags_o    (flags_o),
        .ien_o      (ien_o),
        .irq_o      (irq_o)
    );

    assign ctl_o = cfg_q;
endmodule

// File: rtl/cct_channel_chk.sv
module cct_channel_chk
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input cct_state_e        state,
    input logic              cnt_clr_i,
    input logic [W-1:0]      cnt_o,
    input logic [W-1:0]      reg_a_o,
    input logic [W-1:0]      reg_b_o,
    input logic [NFLAGS-1:0] flags_o,
    input logic              pwm_o
);
    // R1: counter holds in STOP unless cleared
    p_hold_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_STOP && !cnt_clr_i) |=> $stable(cnt_o));

    // R1: counter only steps by one or returns to zero
    p_step_or_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cnt_o) |-> (cnt_o == W'($past(cnt_o) + W'(1)) || cnt_o == '0));

    // R2: software clear yields zero
    p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr_i |=> cnt_o == '0);

    // R6: PWM low while stopped
    p_pwm_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_STOP) |-> !pwm_o);

    // R7: active A changes in compare mode only at a period restart
    p_active_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(reg_a_o) && $past(state) == ST_RUN_CMP) |-> cnt_o == '0);

    // R8: capture A flag rises with the counter value latched
    p_capture_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(flags_o[FLG_CAPA]) && !$past(cnt_clr_i)) |-> reg_a_o == $past(cnt_o));

    // R5: no A match unless A is below B
    p_no_a_when_ge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags_o[FLG_CMPA]) |-> $past(reg_a_o < reg_b_o));
endmodule

bind cct_channel cct_channel_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state    (state),
    .cnt_clr_i(cnt_clr_i),
    .cnt_o    (cnt_o),
    .reg_a_o  (reg_a_o),
    .reg_b_o  (reg_b_o),
    .flags_o  (flags_o),
    .pwm_o    (pwm_o)
);

// File: tb/cct_channel_tb.sv
`timescale 1ns/1ps
module cct_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, ext_evt = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
    logic        ctl_we = 1'b0, cnt_clr = 1'b0, buf_a_we = 1'b0, buf_b_we = 1'b0;
    logic        ien_we = 1'b0, flag_clr_we = 1'b0;
    logic [15:0] wdata = '0;
    logic [2:0]  ctl;
    logic [15:0] cnt, reg_a, reg_b;
    logic [5:0]  flags;
    logic [3:0]  ien;
    logic        pwm, irq;
    int          checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    cct_channel u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_evt_i(ext_evt),
        .cap_a_i(cap_a), .cap_b_i(cap_b), .ctl_we_i(ctl_we), .cnt_clr_i(cnt_clr),
        .buf_a_we_i(buf_a_we), .buf_b_we_i(buf_b_we), .ien_we_i(ien_we),
        .flag_clr_we_i(flag_clr_we), .wdata_i(wdata), .ctl_o(ctl), .cnt_o(cnt),
        .reg_a_o(reg_a), .reg_b_o(reg_b), .flags_o(flags), .ien_o(ien),
        .pwm_o(pwm), .irq_o(irq)
    );

    // {A, B, pulses, expected count, expected pwm}
    localparam int NVEC = 8;
    localparam logic [56:0] VEC [NVEC] = '{
        {16'd2, 16'd5, 8'd3, 16'd3, 1'b1},
        {16'd2, 16'd5, 8'd6, 16'd0, 1'b0},
        {16'd2, 16'd5, 8'd8, 16'd2, 1'b0},
        {16'd5, 16'd5, 8'd5, 16'd5, 1'b0},
        {16'd7, 16'd3, 8'd6, 16'd2, 1'b0},
        {16'd0, 16'd4, 8'd1, 16'd1, 1'b1},
        {16'd0, 16'd0, 8'd3, 16'd0, 1'b0},
        {16'd1, 16'd3, 8'd4, 16'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic strobe(ref logic s, input logic [15:0] d);
        @(negedge clk); s = 1'b1; wdata = d;
        @(negedge clk); s = 1'b0; wdata = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_pin(ref logic p);
        @(negedge clk); p = 1'b1;
        repeat (4) @(negedge clk);
        p = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic setup_cmp(input logic [15:0] a, input logic [15:0] b);
        strobe(ctl_we, 16'h0);
        strobe(buf_a_we, a);
        strobe(buf_b_we, b);
        strobe(cnt_clr, 16'h0);
        strobe(ctl_we, 16'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 cnt", cnt, 0);
        chk("R11 reg_a", reg_a, 0);
        chk("R11 flags", flags, 0);
        chk("R11 pwm/irq", {pwm, irq}, 0);
        chk("R12 ctl", ctl, 0);

        // R4 R5 vector walk
        for (int i = 0; i < NVEC; i++) begin
            setup_cmp(VEC[i][56:41], VEC[i][40:25]);
            ticks(int'(VEC[i][24:17]));
            chk($sformatf("R4 vec%0d cnt", i), cnt, VEC[i][16:1]);
            chk($sformatf("R5 vec%0d pwm", i), pwm, VEC[i][0]);
        end
        chk("R12 ctl run", ctl, 3'b001);

        // R10 flags and interrupt
        strobe(flag_clr_we, 16'h3F);
        chk("R10 w1c all", flags, 0);
        setup_cmp(16'd1, 16'd3);
        ticks(4);
        chk("R10 flags A and B", flags, 6'b000011);
        chk("R10 irq masked", irq, 0);
        strobe(ien_we, 16'h2);
        chk("R10 ien", ien, 4'h2);
        chk("R10 irq enabled", irq, 1);
        strobe(flag_clr_we, 16'h2);
        chk("R10 w1c one", flags, 6'b000001);
        chk("R10 irq cleared", irq, 0);
        strobe(ien_we, 16'h0);

        // R5 A >= B gives no A flag
        strobe(flag_clr_we, 16'h3F);
        setup_cmp(16'd6, 16'd2);
        ticks(6);
        chk("R5 only B flag", flags, 6'b000010);
        chk("R5 pwm low", pwm, 0);

        // R7 shadow buffers
        setup_cmp(16'd2, 16'd5);
        ticks(3);
        strobe(buf_a_we, 16'd4);
        chk("R7 active A held", reg_a, 2);
        ticks(3);
        chk("R7 wrap cnt", cnt, 0);
        chk("R7 active A loaded", reg_a, 4);

        // R6 R1 stop behaviour, R2 clear
        ticks(5);
        chk("R6 pwm high", pwm, 1);
        strobe(ctl_we, 16'h0);
        chk("R6 pwm forced low", pwm, 0);
        ticks(3);
        chk("R1 hold stopped", cnt, 5);
        strobe(cnt_clr, 16'h0);
        chk("R2 clear", cnt, 0);

        // R3 external source, internal tick held active and ignored
        strobe(buf_b_we, 16'd100);
        strobe(cnt_clr, 16'h0);
        strobe(ctl_we, 16'h3);
        tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_evt = 1'b1;
            repeat (3) @(negedge clk);
            ext_evt = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick = 1'b0;
        chk("R3 ext count", cnt, 4);

        // R8 R9 capture
        strobe(ctl_we, 16'h0);
        strobe(flag_clr_we, 16'h3F);
        strobe(cnt_clr, 16'h0);
        strobe(ctl_we, 16'h5);
        chk("R12 ctl cap", ctl, 3'b101);
        ticks(9);
        chk("R8 no B restart", cnt, 9);
        pulse_pin(cap_a);
        chk("R8 cap A value", reg_a, 9);
        chk("R8 cap A flag", flags, 6'b000100);
        ticks(3);
        pulse_pin(cap_b);
        chk("R8 cap B value", reg_b, 12);
        chk("R8 cap B flag", flags, 6'b001100);
        pulse_pin(cap_a);
        chk("R9 overrun A", flags, 6'b011100);
        chk("R9 cap A again", reg_a, 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule